// File: doc/BRIEF.md
# Polled Serial Port with Status Folded into Data Words

A byte-wide asynchronous serial port reached through a 32-bit word register port. Software loads bytes into an eight-entry transmit queue and drains an eight-entry receive queue. Each data word reports its own queue status in its top bit, so one access both checks and transfers a byte. The transmitter and the receiver each have their own enable. A single divisor sets the bit period for both directions. Fill-level thresholds drive two pending flags, and an enable mask turns those flags into one interrupt line.

Frames carry no parity. Each frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. The line rests high between frames. The receiver synchronises its input and finds the middle of each bit by counting clocks from the falling edge. It throws away any frame whose stop bit is low, and it waits for the line to return high before it looks for a new start bit.

The register port takes a request in every cycle it is offered. A read answers with `rsp_valid` one cycle later.

Top module: `uart_folded`

## Requirements
- R1: After reset `tx_line` is 1 and `irq` is 0. The transmit data word reads 0x00000000, the receive data word reads 0x80000000, and the pending, enable and divisor words read 0.
- R2: Word offset 0x00 (transmit data) reads bit 31 = 1 exactly when the transmit queue holds 8 bytes. A write there while the queue is full is discarded, and the byte never appears on the line.
- R3: Word offset 0x04 (receive data) reads, when the receive queue is not empty, bit 31 = 0 and bits 7:0 = the oldest byte, and the read removes that byte. Bytes come out in arrival order.
- R4: A read of 0x04 while the receive queue is empty returns 0x80000000 and changes no queue state.
- R5: With divisor word 0x18 = d, every transmitted bit lasts d+1 clocks. The frame is start=0, data LSB first, stop=1.
- R6: Bit 0 of word 0x08 enables the transmitter. While it is 0, no frame starts and `tx_line` stays 1.
- R7: Bit 0 of word 0x0C enables the receiver. While it is 0, incoming frames are ignored.
- R8: A received frame whose stop bit samples 0 is discarded, and the next valid frame is received correctly.
- R9: Pending word 0x14 bit 0 is 1 exactly when the transmit queue count is below the threshold in word 0x08 bits 18:16.
- R10: Pending bit 1 is 1 exactly when the receive queue count exceeds the threshold in word 0x0C bits 18:16.
- R11: `irq` is the OR of (word 0x10 bits 1:0) AND (pending bits 1:0). With word 0x10 = 0, `irq` stays 0 while the pending flags still read their raw values.
- R12: A request answers with `rsp_valid` the next cycle, and only then. Offset 0x1C and unaligned addresses read 0. The divisor and enable words read back what was written.
- R13: A frame that arrives while the receive queue is full is dropped, and the queued bytes are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after the request) |
| rsp_rdata | output | 32 | Read data |
| tx_line | output | 1 | Serial output, idles high |
| rx_line | input | 1 | Serial input |
| irq | output | 1 | Masked pending OR |

## Verification
The bench builds the block with 8-entry queues and an 8-bit divisor. Because the divisor is that small, every divisor from 0 to 5 can be swept. The bench sends all 256 byte values at divisor 0 and a spread of values at divisors 1 to 5. It checks the first and the last clock of every bit period, which would expose a period that is one clock off. The shallow queues make it cheap to reach both full conditions, every watermark crossing, and the dropped-write and dropped-frame cases. Those cases are driven both through a transmit-to-receive loopback and by frames the bench drives directly.

// File: rtl/uart_folded_pkg.sv
package uart_folded_pkg;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned WM_LSB = 16;
    localparam int unsigned FLAG_BIT = 31;

    typedef enum logic [2:0] {
        SEL_TXDATA = 3'd0,
        SEL_RXDATA = 3'd1,
        SEL_TXCTRL = 3'd2,
        SEL_RXCTRL = 3'd3,
        SEL_IE     = 3'd4,
        SEL_IP     = 3'd5,
        SEL_DIV    = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    typedef enum logic [2:0] {
        RX_IDLE  = 3'd0,
        RX_START = 3'd1,
        RX_DATA  = 3'd2,
        RX_STOP  = 3'd3,
        RX_BREAK = 3'd4
    } rx_state_e;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WIDTH-1:0]           wdata,
    input  logic                       pop,
    output logic [WIDTH-1:0]           rdata,
    output logic [$clog2(DEPTH):0]     count,
    output logic                       full,
    output logic                       empty
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wp;
        logic [AW-1:0]               rp;
        logic [CW-1:0]               cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_push, do_pop;

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CW'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.wp] = wdata;
            d.wp        = q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.mem[q.rp];
    assign count = q.cnt;
    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);
endmodule

// File: rtl/uart_tx.sv
module uart_tx #(
    parameter int unsigned DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             avail,
    input  logic [7:0]       data,
    output logic             pop,
    output logic             line,
    output logic             busy
);
    typedef struct packed {
        logic             busy;
        logic [9:0]       shift;
        logic [3:0]       bits;
        logic [DIV_W-1:0] cnt;
    } tx_t;

    tx_t  q, d;
    logic last;

    always_comb begin
        d    = q;
        pop  = 1'b0;
        last = q.busy && (q.cnt == '0) && (q.bits == 4'd0);
        if (q.busy && (q.cnt != '0)) begin
            d.cnt = q.cnt - 1'b1;
        end else if (q.busy && !last) begin
            d.shift = {1'b1, q.shift[9:1]};
            d.bits  = q.bits - 1'b1;
            d.cnt   = div;
        end else if (en && avail) begin
            pop     = 1'b1;
            d.busy  = 1'b1;
            d.shift = {1'b1, data, 1'b0};
            d.bits  = 4'd9;
            d.cnt   = div;
        end else begin
            d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line = !q.busy || q.shift[0];
    assign busy = q.busy;
endmodule

// File: rtl/uart_rx.sv
module uart_rx
    import uart_folded_pkg::*;
#(
    parameter int unsigned DIV_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    input  logic             line,
    output logic             push,
    output logic [7:0]       data
);
    typedef struct packed {
        logic [1:0]       sync;
        rx_state_e        st;
        logic [DIV_W-1:0] cnt;
        logic [2:0]       idx;
        logic [7:0]       sh;
    } rx_t;

    rx_t              q, d;
    logic             s;
    logic [DIV_W-1:0] half;

    always_comb begin
        d      = q;
        push   = 1'b0;
        s      = q.sync[1];
        half   = div >> 1;
        d.sync = {q.sync[0], line};
        if (!en) begin
            d.st = RX_IDLE;
        end else if (q.st == RX_IDLE) begin
            if (!s) begin
                if (half == '0) begin
                    d.st  = RX_DATA;
                    d.cnt = div;
                    d.idx = 3'd0;
                end else begin
                    d.st  = RX_START;
                    d.cnt = half - 1'b1;
                end
            end
        end else if (q.st == RX_BREAK) begin
            if (s) d.st = RX_IDLE;
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end else begin
            case (q.st)
                RX_START: begin
                    if (!s) begin
                        d.st  = RX_DATA;
                        d.cnt = div;
                        d.idx = 3'd0;
                    end else begin
                        d.st = RX_IDLE;
                    end
                end
                RX_DATA: begin
                    d.sh  = {s, q.sh[7:1]};
                    d.cnt = div;
                    d.idx = q.idx + 1'b1;
                    if (q.idx == 3'd7) d.st = RX_STOP;
                end
                RX_STOP: begin
                    push = s;
                    d.st = s ? RX_IDLE : RX_BREAK;
                end
                default: d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.sync <= 2'b11;
        end else begin
            q <= d;
        end
    end

    assign data = q.sh;
endmodule

// File: rtl/uart_folded.sv
module uart_folded
    import uart_folded_pkg::*;
#(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DIV_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              tx_line,
    input  logic              rx_line,
    output logic              irq
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned CW = AW + 1;

    typedef struct packed {
        logic             txen;
        logic [AW-1:0]    txwm;
        logic             rxen;
        logic [AW-1:0]    rxwm;
        logic [1:0]       ie;
        logic [DIV_W-1:0] div;
        logic             rsp_valid;
        logic [31:0]      rsp_rdata;
    } regs_t;

    regs_t         q, d;
    reg_sel_e      sel;
    logic          wr, rd;
    logic [1:0]    ip;

    logic          tx_push, tx_pop, tx_full, tx_empty, tx_busy;
    logic [7:0]    tx_head;
    logic [CW-1:0] tx_count;
    logic          rx_push, rx_fifo_push, rx_pop, rx_full, rx_empty;
    logic [7:0]    rx_byte, rx_head;
    logic [CW-1:0] rx_count;
    logic          txen_w;
    logic [1:0]    ie_w;

    always_comb begin
        d       = q;
        sel     = (req_addr[1:0] == 2'b00) ? reg_sel_e'(req_addr[ADDR_W-1:2]) : SEL_NONE;
        wr      = req_valid && req_write;
        rd      = req_valid && !req_write;
        tx_push = wr && (sel == SEL_TXDATA) && !tx_full;
        rx_pop  = rd && (sel == SEL_RXDATA) && !rx_empty;
        ip      = {(rx_count > CW'(q.rxwm)), (tx_count < CW'(q.txwm))};

        if (wr) begin
            case (sel)
                SEL_TXCTRL: begin
                    d.txen = req_wdata[0];
                    d.txwm = req_wdata[WM_LSB +: AW];
                end
                SEL_RXCTRL: begin
                    d.rxen = req_wdata[0];
                    d.rxwm = req_wdata[WM_LSB +: AW];
                end
                SEL_IE:  d.ie  = req_wdata[1:0];
                SEL_DIV: d.div = req_wdata[DIV_W-1:0];
                default: ;
            endcase
        end

        d.rsp_valid = req_valid;
        d.rsp_rdata = '0;
        if (rd) begin
            case (sel)
                SEL_TXDATA: d.rsp_rdata[FLAG_BIT] = tx_full;
                SEL_RXDATA: begin
                    if (rx_empty) d.rsp_rdata[FLAG_BIT] = 1'b1;
                    else          d.rsp_rdata[7:0]      = rx_head;
                end
                SEL_TXCTRL: begin
                    d.rsp_rdata[0]            = q.txen;
                    d.rsp_rdata[WM_LSB +: AW] = q.txwm;
                end
                SEL_RXCTRL: begin
                    d.rsp_rdata[0]            = q.rxen;
                    d.rsp_rdata[WM_LSB +: AW] = q.rxwm;
                end
                SEL_IE:  d.rsp_rdata[1:0]       = q.ie;
                SEL_IP:  d.rsp_rdata[1:0]       = ip;
                SEL_DIV: d.rsp_rdata[DIV_W-1:0] = q.div;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_fifo_push = rx_push && !rx_full;
    assign rsp_valid    = q.rsp_valid;
    assign rsp_rdata    = q.rsp_rdata;
    assign irq          = |(q.ie & ip);
    assign txen_w       = q.txen;
    assign ie_w         = q.ie;

    uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(req_wdata[7:0]),
        .pop(tx_pop), .rdata(tx_head), .count(tx_count),
        .full(tx_full), .empty(tx_empty)
    );

    uart_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_fifo_push), .wdata(rx_byte),
        .pop(rx_pop), .rdata(rx_head), .count(rx_count),
        .full(rx_full), .empty(rx_empty)
    );

    uart_tx #(.DIV_W(DIV_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .en(q.txen), .div(q.div),
        .avail(!tx_empty), .data(tx_head), .pop(tx_pop),
        .line(tx_line), .busy(tx_busy)
    );

    uart_rx #(.DIV_W(DIV_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .en(q.rxen), .div(q.div),
        .line(rx_line), .push(rx_push), .data(rx_byte)
    );
endmodule

// File: rtl/uart_folded_chk.sv
module uart_folded_chk #(
    parameter int unsigned CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_write,
    input logic [4:0]    req_addr,
    input logic          rsp_valid,
    input logic          tx_line,
    input logic          irq,
    input logic          txen_w,
    input logic [1:0]    ie_w,
    input logic          tx_busy,
    input logic          tx_full,
    input logic          tx_pop,
    input logic [CW-1:0] tx_count,
    input logic          rx_empty,
    input logic          rx_fifo_push,
    input logic [CW-1:0] rx_count
);
    // R12: every request answers on the next cycle
    a_r12_rsp_next: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R12: no answer without a request
    a_r12_rsp_only: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R2: a write to a full transmit queue leaves its fill unchanged
    a_r2_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == 5'h00 && tx_full && !tx_pop)
        |=> tx_count == $past(tx_count));

    // R4: a read of an empty receive queue leaves its fill unchanged
    a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_addr == 5'h04 && rx_empty && !rx_fifo_push)
        |=> rx_count == $past(rx_count));

    // R11: a zero mask keeps the interrupt low
    a_r11_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_w == 2'b00) |-> !irq);

    // R6: a disabled, idle transmitter keeps the line high
    a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!txen_w && !tx_busy) |=> tx_line);
endmodule

bind uart_folded uart_folded_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .tx_line(tx_line), .irq(irq),
    .txen_w(txen_w), .ie_w(ie_w), .tx_busy(tx_busy), .tx_full(tx_full),
    .tx_pop(tx_pop), .tx_count(tx_count), .rx_empty(rx_empty),
    .rx_fifo_push(rx_fifo_push), .rx_count(rx_count)
);

// File: tb/sim_uart_folded.sv
module sim_uart_folded;
    localparam int DEPTH = 8;
    localparam int DIV_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        tx_line;
    logic        rx_line;
    logic        irq;
    logic        loop = 1'b1;
    logic        drv_rx = 1'b1;
    int          checks = 0;
    int          errors = 0;
    int          dcur = 0;

    always #10 clk = ~clk;
    assign rx_line = loop ? tx_line : drv_rx;

    uart_folded #(.DEPTH(DEPTH), .DIV_W(DIV_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .tx_line(tx_line), .rx_line(rx_line), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = v;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = '0;
        @(negedge clk);
        v = rsp_rdata;
        chk("R12 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        req_valid = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [4:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R5: check both ends of every bit period of the next frame on tx_line
    task automatic sniff(input logic [7:0] b, input int d);
        int wait_n = 0;
        int pos = 0;
        while (tx_line !== 1'b0 && wait_n < 60) begin
            @(negedge clk);
            wait_n++;
        end
        chk("R5 start seen", {31'd0, tx_line}, 32'd0);
        for (int k = 0; k < 10; k++) begin
            logic e, a0, a1;
            e = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : b[k-1];
            repeat (k * (d + 1) - pos) @(negedge clk);
            pos = k * (d + 1);
            a0 = tx_line;
            repeat (d) @(negedge clk);
            pos = pos + d;
            a1 = tx_line;
            chk("R5 bit", {30'd0, a0, a1}, {30'd0, e, e});
        end
    endtask

    task automatic loop_byte(input logic [7:0] b, input int d);
        wr(5'h00, {24'd0, b});
        sniff(b, d);
        idle(4);
        rdchk("R3 loopback byte", 5'h04, {24'd0, b});
    endtask

    task automatic drive_frame(input logic [7:0] b, input logic stopv);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            drv_rx = (k == 0) ? 1'b0 : (k == 9) ? stopv : b[k-1];
            repeat (dcur) @(negedge clk);
        end
        @(negedge clk);
        drv_rx = 1'b1;
        idle(2 * (dcur + 1) + 4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk("R1 tx_line", {31'd0, tx_line}, 32'd1);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rdchk("R1 txdata", 5'h00, 32'h0);
        rdchk("R1 rxdata", 5'h04, 32'h8000_0000);
        rdchk("R1 ip", 5'h14, 32'h0);
        rdchk("R1 ie", 5'h10, 32'h0);
        rdchk("R1 div", 5'h18, 32'h0);

        wr(5'h08, 32'h1);
        wr(5'h0C, 32'h1);

        // R5 and R3: divisor sweep with loopback
        for (int d = 0; d < 6; d++) begin
            dcur = d;
            wr(5'h18, d);
            rdchk("R12 div readback", 5'h18, d);
            for (int i = 0; i < ((d == 0) ? 256 : 24); i++) begin
                logic [7:0] b;
                b = (d == 0) ? 8'(i) : 8'(i * 37 + d * 11);
                loop_byte(b, d);
            end
        end

        // R4: empty reads change nothing
        dcur = 1;
        wr(5'h18, 1);
        rdchk("R4 empty read", 5'h04, 32'h8000_0000);
        rdchk("R4 empty read again", 5'h04, 32'h8000_0000);
        rdchk("R4 ip after empty read", 5'h14, 32'h0);
        loop_byte(8'h3C, 1);
        rdchk("R4 empty after one", 5'h04, 32'h8000_0000);

        // R12: unmapped and unaligned
        rdchk("R12 unmapped", 5'h1C, 32'h0);
        rdchk("R12 unaligned", 5'h05, 32'h0);
        rdchk("R12 txctrl readback", 5'h08, 32'h1);

        // R2: full transmit queue, ninth write dropped
        wr(5'h08, 32'h0);
        for (int i = 0; i < 8; i++) wr(5'h00, 32'hA0 + i);
        rdchk("R2 full flag", 5'h00, 32'h8000_0000);
        wr(5'h00, 32'hFF);
        rdchk("R2 still full", 5'h00, 32'h8000_0000);
        wr(5'h08, 32'h1);
        idle(100);
        rdchk("R2 no longer full", 5'h00, 32'h0);
        for (int i = 0; i < 4; i++) rdchk("R3 order first half", 5'h04, 32'hA0 + i);
        idle(200);
        for (int i = 4; i < 8; i++) rdchk("R3 order second half", 5'h04, 32'hA0 + i);
        rdchk("R2 dropped write never sent", 5'h04, 32'h8000_0000);

        // R13 and R10: full receive queue
        for (int i = 0; i < 8; i++) wr(5'h00, 32'hB0 + i);
        idle(200);
        wr(5'h0C, 32'h1 | (32'd7 << 16));
        rdchk("R10 count 8 above 7", 5'h14, 32'h2);
        wr(5'h00, 32'h55);
        idle(40);
        rdchk("R13 oldest kept", 5'h04, 32'hB0);
        rdchk("R10 count 7 not above 7", 5'h14, 32'h0);
        wr(5'h0C, 32'h1 | (32'd6 << 16));
        rdchk("R10 count 7 above 6", 5'h14, 32'h2);
        rdchk("R12 rxctrl readback", 5'h0C, 32'h0006_0001);
        for (int i = 1; i < 8; i++) rdchk("R13 queued bytes kept", 5'h04, 32'hB0 + i);
        rdchk("R13 frame on full queue dropped", 5'h04, 32'h8000_0000);

        // R9 and R6: transmit watermark with the transmitter off
        wr(5'h08, 32'd3 << 16);
        rdchk("R9 count 0 below 3", 5'h14, 32'h1);
        for (int i = 0; i < 3; i++) wr(5'h00, 32'hC0 + i);
        rdchk("R9 count 3 not below 3", 5'h14, 32'h0);
        wr(5'h08, 32'd4 << 16);
        rdchk("R9 count 3 below 4", 5'h14, 32'h1);
        begin
            int lows = 0;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                if (tx_line !== 1'b1) lows++;
            end
            chk("R6 line held high while disabled", lows, 0);
        end

        // R11: interrupt masking, pending bit 0 raw = 1
        wr(5'h10, 32'h0);
        chk("R11 masked irq", {31'd0, irq}, 32'd0);
        rdchk("R11 raw ip while masked", 5'h14, 32'h1);
        wr(5'h10, 32'h1);
        chk("R11 irq from tx watermark", {31'd0, irq}, 32'd1);
        wr(5'h10, 32'h2);
        chk("R11 irq rx bit clear", {31'd0, irq}, 32'd0);
        rdchk("R12 ie readback", 5'h10, 32'h2);
        wr(5'h10, 32'h0);

        wr(5'h08, 32'h1);
        idle(80);
        for (int i = 0; i < 3; i++) rdchk("R6 queued bytes sent on enable", 5'h04, 32'hC0 + i);

        // R7: receiver disabled
        loop = 1'b0;
        wr(5'h0C, 32'h0);
        drive_frame(8'h5A, 1'b1);
        wr(5'h0C, 32'h1);
        rdchk("R7 frame ignored", 5'h04, 32'h8000_0000);

        // R8: bad stop bit at two divisors
        for (int d = 1; d < 4; d += 2) begin
            dcur = d;
            wr(5'h18, d);
            drive_frame(8'h5A, 1'b0);
            rdchk("R8 bad stop discarded", 5'h04, 32'h8000_0000);
            drive_frame(8'hC3, 1'b1);
            rdchk("R8 good frame after bad", 5'h04, 32'hC3);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule